// File: doc/BRIEF.md
# Multi-Pattern Parallel Register File

This block is a two-dimensional N x N register file of W-bit elements. The storage is split into a P x Q grid of independent banks. Every access names a base coordinate (row, column) and a pattern code. It then moves P·Q elements at once, one from each bank. A module-assignment function places elements so that every supported pattern touches each bank exactly once. Each bank derives its own local address from the base coordinate and the pattern, so no address crossbar is needed. Only the data passes through a lane shuffle, which puts the elements back into lane order.

There are two independent read ports and one write port. A parameter selects the pattern set. The default set (SCHEME 0) serves full-length rows and columns at any in-range base, plus P x Q rectangles whose base is aligned to multiples of P and Q. SCHEME 1 serves P x Q and Q x P rectangles at any in-range base, which gives transposed block access. Q x P rectangles need P equal to Q. Requests that the selected set cannot serve are refused and flagged.

Element (i, j) is held in bank ((i + j/Q) mod P, (j + i/P) mod Q) under SCHEME 0, and in bank (i mod P, j mod Q) under SCHEME 1. Under both schemes its local address is (i/P)·(N/Q) + j/Q.

Top module: `mv_regfile`

## Requirements
- R1: Each port moves P·Q elements per access. Lane k occupies data bits [k·W +: W]. Read data and the read error flag appear in the cycle after the request, and a write is visible to reads issued in later cycles.
- R2: Every accepted access uses each of the P·Q banks exactly once, so each lane carries a distinct element.
- R3: Pattern code 1 (row) delivers element (r, c+k) on lane k. It is accepted when c + P·Q ≤ N.
- R4: Pattern code 2 (column) delivers element (r+k, c) on lane k. It is accepted when r + P·Q ≤ N.
- R5: Pattern code 0 (rectangle) delivers element (r + k/Q, c + k mod Q) on lane k. Under the default set it is accepted only when r is a multiple of P and c is a multiple of Q.
- R6: A read and a write to the same element in the same cycle return the old value on the read.
- R7: An access that is refused raises that port's error flag in the following cycle. A refused access is one with an unsupported code (code 3 under the default set), with elements outside the array, or with an unaligned rectangle base. A refused read returns all-zero data for that cycle, and a refused write leaves storage unchanged.
- R8: While a read port's enable is low, its error flag is low and its data holds the result of its last accepted read.
- R9: During and right after reset, all error flags are low and both read data outputs are zero.
- R10: The two read ports work independently, and in the same cycle they may use different patterns and bases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_en | input | 1 | Read port A request |
| ra_row | input | CW | Read port A base row |
| ra_col | input | CW | Read port A base column |
| ra_pat | input | 2 | Read port A pattern code |
| ra_data | output | P·Q·W | Read port A lane data |
| ra_err | output | 1 | Read port A request refused |
| rb_en | input | 1 | Read port B request |
| rb_row | input | CW | Read port B base row |
| rb_col | input | CW | Read port B base column |
| rb_pat | input | 2 | Read port B pattern code |
| rb_data | output | P·Q·W | Read port B lane data |
| rb_err | output | 1 | Read port B request refused |
| w_en | input | 1 | Write request |
| w_row | input | CW | Write base row |
| w_col | input | CW | Write base column |
| w_pat | input | 2 | Write pattern code |
| w_data | input | P·Q·W | Write lane data |
| w_err | output | 1 | Write request refused |

## Verification
The assertions assume that enables, coordinates and pattern codes are known values on every clock edge once reset is released. They also assume that the enables are low throughout reset. On that basis they check the following:
- An accepted request spreads its lanes over all banks.
- A flagged write never had a bank write enable set.
- A flagged read shows zero data.
- An idle read port keeps both its data and its flag steady.

The stimulus drives every input to a defined value from time zero and holds the enables low until reset has been released. The base coordinates come from a table that mixes accepted and refused cases, so the error paths are exercised with ordinary, well-formed inputs.

// File: rtl/mvrf_pkg.sv
package mvrf_pkg;

  typedef enum logic [1:0] {
    PAT_RECT  = 2'd0,
    PAT_ROW   = 2'd1,
    PAT_COL   = 2'd2,
    PAT_TRECT = 2'd3
  } pat_e;

  typedef struct packed {
    int i;
    int j;
  } coord_t;

  function automatic int pmod(int x, int m);
    return ((x % m) + m) % m;
  endfunction

  // True when the selected pattern set can serve this base without conflict.
  function automatic bit pat_legal(int scheme, int p, int q, int n,
                                   logic [1:0] pat, int r, int c);
    if (scheme == 0) begin
      case (pat)
        PAT_ROW:  return (c + p * q) <= n;
        PAT_COL:  return (r + p * q) <= n;
        PAT_RECT: return ((r % p) == 0) && ((c % q) == 0);
        default:  return 1'b0;
      endcase
    end
    case (pat)
      PAT_RECT:  return ((r + p) <= n) && ((c + q) <= n);
      PAT_TRECT: return (p == q) && ((r + q) <= n) && ((c + p) <= n);
      default:   return 1'b0;
    endcase
  endfunction

  // The element of the requested pattern that lives in bank (u, v).
  function automatic coord_t bank_elem(int scheme, int p, int q,
                                       logic [1:0] pat, int r, int c,
                                       int u, int v);
    coord_t e;
    int rr, j0, t, s, i0;
    e.i = r;
    e.j = c;
    if (scheme == 0) begin
      case (pat)
        PAT_ROW: begin
          rr  = pmod(v - r / p, q);
          j0  = c + pmod(rr - c, q);
          t   = pmod(u - r - j0 / q, p);
          e.j = j0 + q * t;
        end
        PAT_COL: begin
          s   = pmod(u - c / q, p);
          i0  = r + pmod(s - r, p);
          t   = pmod(v - c - i0 / p, q);
          e.i = i0 + p * t;
        end
        PAT_RECT: begin
          e.i = r + pmod(u - c / q, p);
          e.j = c + pmod(v - r / p, q);
        end
        default: ;
      endcase
    end else begin
      e.i = r + pmod(u - r, p);
      e.j = c + pmod(v - c, q);
    end
    return e;
  endfunction

  // Lane that carries element e for the given pattern and base.
  function automatic int lane_of(int p, int q, logic [1:0] pat,
                                 int r, int c, coord_t e);
    case (pat)
      PAT_ROW:   return e.j - c;
      PAT_COL:   return e.i - r;
      PAT_TRECT: return (e.i - r) * p + (e.j - c);
      default:   return (e.i - r) * q + (e.j - c);
    endcase
  endfunction

  function automatic int local_addr(int p, int q, int n, coord_t e);
    return (e.i / p) * (n / q) + e.j / q;
  endfunction

endpackage

// File: rtl/mvrf_agu.sv
module mvrf_agu
  import mvrf_pkg::*;
#(
  parameter int P      = 4,
  parameter int Q      = 4,
  parameter int N      = 32,
  parameter int SCHEME = 0,
  localparam int NB    = P * Q,
  localparam int DEPTH = (N / P) * (N / Q),
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(NB),
  localparam int CW    = $clog2(N)
) (
  input  logic [CW-1:0]          row,
  input  logic [CW-1:0]          col,
  input  logic [1:0]             pat,
  output logic                   ok,
  output logic [NB-1:0][AW-1:0]  addr,
  output logic [NB-1:0][LW-1:0]  lane
);

  assign ok = pat_legal(SCHEME, P, Q, N, pat, int'(row), int'(col));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_comb begin
      coord_t e;
      e = bank_elem(SCHEME, P, Q, pat, int'(row), int'(col),
                    int'(b) / Q, int'(b) % Q);
      addr[b] = AW'(local_addr(P, Q, N, e));
      lane[b] = LW'(lane_of(P, Q, pat, int'(row), int'(col), e));
    end
  end

endmodule

// File: rtl/mvrf_bank.sv
module mvrf_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re_a,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rd_a,
  input  logic          re_b,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rd_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Reads sample the array before this edge's write lands: old value wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_a <= '0;
      rd_b <= '0;
    end else begin
      if (re_a) rd_a <= mem[raddr_a];
      if (re_b) rd_b <= mem[raddr_b];
    end
  end

endmodule

// File: rtl/mvrf_gather.sv
module mvrf_gather #(
  parameter int NB  = 16,
  parameter int W   = 16,
  localparam int LW = $clog2(NB)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  ok,
  input  logic [NB-1:0][LW-1:0] lane_in,
  input  logic [NB-1:0][W-1:0]  bank_rd,
  output logic [NB*W-1:0]       data,
  output logic                  err
);

  logic [NB-1:0][LW-1:0] lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      err    <= 1'b0;
    end else begin
      err <= en & ~ok;
      if (en && ok) lane_q <= lane_in;
    end
  end

  always_comb begin
    data = '0;
    if (!err) begin
      for (int b = 0; b < NB; b++) begin
        data[int'(lane_q[b]) * W +: W] = bank_rd[b];
      end
    end
  end

endmodule

// File: rtl/mv_regfile.sv
module mv_regfile
  import mvrf_pkg::*;
#(
  parameter int P      = 4,
  parameter int Q      = 4,
  parameter int N      = 32,
  parameter int W      = 16,
  parameter int SCHEME = 0,
  localparam int NB    = P * Q,
  localparam int DEPTH = (N / P) * (N / Q),
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(NB),
  localparam int CW    = $clog2(N),
  localparam int DW    = NB * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ra_en,
  input  logic [CW-1:0] ra_row,
  input  logic [CW-1:0] ra_col,
  input  logic [1:0]    ra_pat,
  output logic [DW-1:0] ra_data,
  output logic          ra_err,
  input  logic          rb_en,
  input  logic [CW-1:0] rb_row,
  input  logic [CW-1:0] rb_col,
  input  logic [1:0]    rb_pat,
  output logic [DW-1:0] rb_data,
  output logic          rb_err,
  input  logic          w_en,
  input  logic [CW-1:0] w_row,
  input  logic [CW-1:0] w_col,
  input  logic [1:0]    w_pat,
  input  logic [DW-1:0] w_data,
  output logic          w_err
);

  logic                  ra_ok, rb_ok, w_ok;
  logic [NB-1:0][AW-1:0] ra_addr, rb_addr, w_addr;
  logic [NB-1:0][LW-1:0] ra_lane, rb_lane, w_lane;
  logic [NB-1:0]         bank_we;
  logic [NB-1:0][W-1:0]  bank_rd_a, bank_rd_b;
  logic                  ra_fire, rb_fire;

  mvrf_agu #(.P(P), .Q(Q), .N(N), .SCHEME(SCHEME)) u_agu_ra (
    .row(ra_row), .col(ra_col), .pat(ra_pat),
    .ok(ra_ok), .addr(ra_addr), .lane(ra_lane)
  );

  mvrf_agu #(.P(P), .Q(Q), .N(N), .SCHEME(SCHEME)) u_agu_rb (
    .row(rb_row), .col(rb_col), .pat(rb_pat),
    .ok(rb_ok), .addr(rb_addr), .lane(rb_lane)
  );

  mvrf_agu #(.P(P), .Q(Q), .N(N), .SCHEME(SCHEME)) u_agu_w (
    .row(w_row), .col(w_col), .pat(w_pat),
    .ok(w_ok), .addr(w_addr), .lane(w_lane)
  );

  assign ra_fire = ra_en & ra_ok;
  assign rb_fire = rb_en & rb_ok;
  assign bank_we = {NB{w_en & w_ok}};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [W-1:0] wdata_b;
    assign wdata_b = w_data[int'(w_lane[b]) * W +: W];

    mvrf_bank #(.W(W), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we(bank_we[b]), .waddr(w_addr[b]), .wdata(wdata_b),
      .re_a(ra_fire), .raddr_a(ra_addr[b]), .rd_a(bank_rd_a[b]),
      .re_b(rb_fire), .raddr_b(rb_addr[b]), .rd_b(bank_rd_b[b])
    );
  end

  mvrf_gather #(.NB(NB), .W(W)) u_gather_a (
    .clk(clk), .rst_n(rst_n), .en(ra_en), .ok(ra_ok),
    .lane_in(ra_lane), .bank_rd(bank_rd_a), .data(ra_data), .err(ra_err)
  );

  mvrf_gather #(.NB(NB), .W(W)) u_gather_b (
    .clk(clk), .rst_n(rst_n), .en(rb_en), .ok(rb_ok),
    .lane_in(rb_lane), .bank_rd(bank_rd_b), .data(rb_data), .err(rb_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w_err <= 1'b0;
    else        w_err <= w_en & ~w_ok;
  end

endmodule

// File: rtl/mv_regfile_chk.sv
module mv_regfile_chk #(
  parameter int NB  = 16,
  parameter int W   = 16,
  parameter int LW  = 4,
  localparam int DW = NB * W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ra_en,
  input logic                  ra_ok,
  input logic [NB-1:0][LW-1:0] ra_lane,
  input logic [DW-1:0]         ra_data,
  input logic                  ra_err,
  input logic                  rb_en,
  input logic                  rb_ok,
  input logic [NB-1:0][LW-1:0] rb_lane,
  input logic [DW-1:0]         rb_data,
  input logic                  rb_err,
  input logic                  w_en,
  input logic                  w_ok,
  input logic [NB-1:0][LW-1:0] w_lane,
  input logic [NB-1:0]         bank_we,
  input logic                  w_err
);

  function automatic logic [NB-1:0] lanes_hit(logic [NB-1:0][LW-1:0] l);
    logic [NB-1:0] h;
    h = '0;
    for (int b = 0; b < NB; b++) h[l[b]] = 1'b1;
    return h;
  endfunction

  logic [NB-1:0] ra_hit, rb_hit, w_hit;
  assign ra_hit = lanes_hit(ra_lane);
  assign rb_hit = lanes_hit(rb_lane);
  assign w_hit  = lanes_hit(w_lane);

  assert_ra_conflict_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_en && ra_ok) |-> (&ra_hit));
  assert_rb_conflict_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_en && rb_ok) |-> (&rb_hit));
  assert_w_conflict_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_en && w_ok) |-> (&w_hit));

  assert_refused_write_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w_err |-> ($past(bank_we) == '0));
  assert_ra_refused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ra_err |-> (ra_data == '0));
  assert_rb_refused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rb_err |-> (rb_data == '0));

  assert_ra_idle_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ra_en) |-> !ra_err);
  assert_rb_idle_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rb_en) |-> !rb_err);
  assert_ra_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ra_en) && !$past(ra_err)) |-> $stable(ra_data));
  assert_rb_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rb_en) && !$past(rb_err)) |-> $stable(rb_data));

endmodule

bind mv_regfile mv_regfile_chk #(.NB(NB), .W(W), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ra_en(ra_en), .ra_ok(ra_ok), .ra_lane(ra_lane), .ra_data(ra_data), .ra_err(ra_err),
  .rb_en(rb_en), .rb_ok(rb_ok), .rb_lane(rb_lane), .rb_data(rb_data), .rb_err(rb_err),
  .w_en(w_en), .w_ok(w_ok), .w_lane(w_lane), .bank_we(bank_we), .w_err(w_err)
);

// File: tb/mv_regfile_tb.sv
module mv_regfile_tb;

  localparam int P = 4;
  localparam int Q = 4;
  localparam int N = 32;
  localparam int W = 16;
  localparam int NB = P * Q;
  localparam int DW = NB * W;
  localparam int CW = 5;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [1:0]    pat;
    logic [CW-1:0] r;
    logic [CW-1:0] c;
    logic          bad;
  } vec_t;

  // pattern codes: 0 rectangle, 1 row, 2 column, 3 transposed rectangle
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 5'd0,  5'd0,  1'b0},
    '{2'd1, 5'd7,  5'd16, 1'b0},
    '{2'd1, 5'd31, 5'd5,  1'b0},
    '{2'd1, 5'd3,  5'd17, 1'b1},
    '{2'd2, 5'd0,  5'd0,  1'b0},
    '{2'd2, 5'd12, 5'd9,  1'b0},
    '{2'd2, 5'd16, 5'd31, 1'b0},
    '{2'd2, 5'd20, 5'd2,  1'b1},
    '{2'd0, 5'd0,  5'd0,  1'b0},
    '{2'd0, 5'd8,  5'd12, 1'b0},
    '{2'd0, 5'd28, 5'd28, 1'b0},
    '{2'd0, 5'd5,  5'd4,  1'b1},
    '{2'd3, 5'd0,  5'd0,  1'b1},
    '{2'd0, 5'd4,  5'd6,  1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ra_en = 1'b0, rb_en = 1'b0, w_en = 1'b0;
  logic [CW-1:0] ra_row = '0, ra_col = '0, rb_row = '0, rb_col = '0, w_row = '0, w_col = '0;
  logic [1:0]    ra_pat = '0, rb_pat = '0, w_pat = '0;
  logic [DW-1:0] w_data = '0;
  logic [DW-1:0] ra_data, rb_data;
  logic          ra_err, rb_err, w_err;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] refm [N][N];

  always #(CLK_PERIOD/2) clk = ~clk;

  mv_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .ra_en(ra_en), .ra_row(ra_row), .ra_col(ra_col), .ra_pat(ra_pat),
    .ra_data(ra_data), .ra_err(ra_err),
    .rb_en(rb_en), .rb_row(rb_row), .rb_col(rb_col), .rb_pat(rb_pat),
    .rb_data(rb_data), .rb_err(rb_err),
    .w_en(w_en), .w_row(w_row), .w_col(w_col), .w_pat(w_pat),
    .w_data(w_data), .w_err(w_err)
  );

  function automatic void elem(input logic [1:0] pat, input int r, input int c,
                               input int k, output int i, output int j);
    case (pat)
      2'd1:    begin i = r;         j = c + k;     end
      2'd2:    begin i = r + k;     j = c;         end
      2'd0:    begin i = r + k / Q; j = c + k % Q; end
      default: begin i = r + k / P; j = c + k % P; end
    endcase
  endfunction

  function automatic logic [DW-1:0] gen(int seed);
    logic [DW-1:0] v;
    for (int k = 0; k < NB; k++) v[k*W +: W] = W'((seed * 977 + k * 131 + 7) ^ (seed << 5));
    return v;
  endfunction

  function automatic logic [DW-1:0] expect_of(vec_t v);
    logic [DW-1:0] e;
    int i, j;
    e = '0;
    if (!v.bad) begin
      for (int k = 0; k < NB; k++) begin
        elem(v.pat, int'(v.r), int'(v.c), k, i, j);
        e[k*W +: W] = refm[i][j];
      end
    end
    return e;
  endfunction

  function automatic void ref_write(vec_t v, logic [DW-1:0] d);
    int i, j;
    for (int k = 0; k < NB; k++) begin
      elem(v.pat, int'(v.r), int'(v.c), k, i, j);
      refm[i][j] = d[k*W +: W];
    end
  endfunction

  function automatic string tag_of(vec_t v);
    if (v.bad) return "R7";
    case (v.pat)
      2'd1:    return "R1 R2 R3";
      2'd2:    return "R1 R2 R4";
      default: return "R1 R2 R5";
    endcase
  endfunction

  task automatic chk_vec(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s data act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s flag act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic set_w(vec_t v, logic [DW-1:0] d);
    w_en = 1'b1; w_pat = v.pat; w_row = v.r; w_col = v.c; w_data = d;
  endtask

  task automatic set_a(vec_t v);
    ra_en = 1'b1; ra_pat = v.pat; ra_row = v.r; ra_col = v.c;
  endtask

  task automatic set_b(vec_t v);
    rb_en = 1'b1; rb_pat = v.pat; rb_row = v.r; rb_col = v.c;
  endtask

  task automatic step;
    @(negedge clk);
    ra_en = 1'b0; rb_en = 1'b0; w_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t va, vb, vw;
    logic [DW-1:0] d, old_e;
    int seed;
    seed = 1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk_vec("R9 ra_data", ra_data, '0);
    chk_vec("R9 rb_data", rb_data, '0);
    chk_bit("R9 ra_err", ra_err, 1'b0);
    chk_bit("R9 rb_err", rb_err, 1'b0);
    chk_bit("R9 w_err", w_err, 1'b0);

    // Fill the whole array through row writes.
    for (int r = 0; r < N; r++) begin
      for (int h = 0; h < 2; h++) begin
        vw = '{2'd1, CW'(r), CW'(h * 16), 1'b0};
        d = gen(seed++);
        set_w(vw, d);
        step();
        ref_write(vw, d);
      end
    end

    // Table walk: write each vector, then read it on A and another on B.
    for (int idx = 0; idx < NVEC; idx++) begin
      vw = VECS[idx];
      d = gen(seed++);
      set_w(vw, d);
      step();
      chk_bit({tag_of(vw), " w_err"}, w_err, vw.bad);
      if (!vw.bad) ref_write(vw, d);

      va = VECS[idx];
      vb = VECS[(idx + 5) % NVEC];
      set_a(va);
      set_b(vb);
      step();
      chk_bit({tag_of(va), " ra_err"}, ra_err, va.bad);
      chk_vec({tag_of(va), " ra_data"}, ra_data, expect_of(va));
      chk_bit({tag_of(vb), " R10 rb_err"}, rb_err, vb.bad);
      chk_vec({tag_of(vb), " R10 rb_data"}, rb_data, expect_of(vb));
    end

    // R6: same-cycle read and write of one row return the old contents.
    va = '{2'd1, 5'd5, 5'd0, 1'b0};
    old_e = expect_of(va);
    d = gen(seed++);
    set_w(va, d);
    set_a(va);
    step();
    chk_vec("R6 old value", ra_data, old_e);
    ref_write(va, d);
    set_a(va);
    step();
    chk_vec("R6 R1 new value next cycle", ra_data, expect_of(va));

    // R7: refused transposed write leaves the rectangle untouched.
    vw = '{2'd3, 5'd0, 5'd0, 1'b1};
    set_w(vw, gen(seed++));
    step();
    chk_bit("R7 w_err transposed", w_err, 1'b1);
    va = '{2'd0, 5'd0, 5'd0, 1'b0};
    set_a(va);
    step();
    chk_vec("R7 storage unchanged", ra_data, expect_of(va));

    // R8: legal read, refused read, then idle shows the last legal result.
    va = '{2'd2, 5'd3, 5'd7, 1'b0};
    set_a(va);
    step();
    chk_vec("R4 column read", ra_data, expect_of(va));
    vb = '{2'd1, 5'd0, 5'd20, 1'b1};
    set_a(vb);
    step();
    chk_bit("R7 ra_err out of range", ra_err, 1'b1);
    chk_vec("R7 ra_data zero", ra_data, '0);
    step();
    chk_bit("R8 ra_err idle", ra_err, 1'b0);
    chk_vec("R8 ra_data held", ra_data, expect_of(va));
    step();
    chk_vec("R8 ra_data still held", ra_data, expect_of(va));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule